// File: doc/BRIEF.md
# Tagged Receive Silo with Fill Alarm

This block is a first-in first-out store for characters that arrive from many serial lines. Each write carries an 8-bit character, the 4-bit number of the line that delivered it, and three error flags. The silo keeps up to 64 such entries. The oldest entry is always shown on a read-once output word. A read strobe consumes that entry, and the next one takes its place on the following cycle.

Two requests leave the block. The receive request stays high while the number of stored entries is above a 6-bit alarm level. Software loads that level through a write strobe. The overflow request is a sticky flag. It is set when a character arrives at a full silo, and it stays set until software clears it. The current fill count is also an output, so the host can poll it.

Top module: `rx_silo`

## Requirements
- R1: The output word uses this layout: bits 7:0 hold the character, bits 11:8 the line number, bit 12 the parity error, bit 13 the framing error, bit 14 the overrun, and bit 15 a valid bit. The valid bit is 1 whenever the silo holds at least one entry.
- R2: Entries leave in the order they were written. The silo holds 64 entries.
- R3: An accepted write with no read raises fill_o by one on the next cycle. A read of a non-empty silo with no write lowers it by one. A read and a write in the same cycle leave it unchanged.
- R4: While the silo is empty, the output word is all zero, including the valid bit. A read strobe then leaves fill_o at 0.
- R5: rx_irq_o is high exactly when fill_o is greater than the alarm level. The alarm level is a 6-bit value, loaded from alarm_val_i on a cycle with alarm_we_i high.
- R6: A write to a full silo with no read in the same cycle is dropped. fill_o stays at 64, the stored entries do not change, and ovf_o is 1 from the next cycle.
- R7: ovf_o holds at 1 until a cycle with ovf_clr_i high and no new overflow. If a new overflow and a clear fall in the same cycle, the overflow wins.
- R8: When the silo is full, a write that comes with a read in the same cycle is accepted. That write does not set ovf_o, and its entry becomes the newest one.
- R9: After reset, fill_o, rx_irq_o and ovf_o are 0, the output word is zero, and the alarm level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for a received character |
| wr_char_i | input | 8 | Received character |
| wr_line_i | input | 4 | Number of the source line |
| wr_par_err_i | input | 1 | Parity error flag |
| wr_frm_err_i | input | 1 | Framing error flag |
| wr_ovr_i | input | 1 | Receiver overrun flag |
| rd_en_i | input | 1 | Read strobe; consumes the entry shown on rd_entry_o |
| rd_entry_o | output | 16 | Oldest entry (all zero when empty) |
| fill_o | output | 7 | Number of stored entries, 0 to 64 |
| alarm_we_i | input | 1 | Load strobe for the alarm level |
| alarm_val_i | input | 6 | New alarm level |
| rx_irq_o | output | 1 | Receive request: fill above alarm level |
| ovf_o | output | 1 | Sticky overflow request |
| ovf_clr_i | input | 1 | Clears the overflow request |

## Verification
The assertions assume that the input strobes are known and are sampled only at clock edges. They also assume that a read strobe is taken as consuming whatever rd_entry_o shows in that same cycle. The bench drives every input one time unit after a rising edge and checks results at that same point. Each input therefore stays stable across a full edge, and every read is checked against the word shown just before it is consumed. The bench never drives a clear alone while it is checking an overflow.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 4;

  typedef struct packed {
    logic              valid;
    logic              ovr_err;
    logic              frm_err;
    logic              par_err;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] chr;
  } silo_entry_t;

  localparam int ENTRY_W   = $bits(silo_entry_t);
  localparam int PAYLOAD_W = ENTRY_W - 1;
endpackage

// File: rtl/rx_silo_mem.sv
module rx_silo_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= wrap_inc(rd_ptr_q);
    end
  end

  // storage needs no reset; valid is derived from the fill count
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/rx_silo_level.sv
module rx_silo_level #(
  parameter int DEPTH   = 64,
  parameter int ALARM_W = 6,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               alarm_we_i,
  input  logic [ALARM_W-1:0] alarm_val_i,
  output logic [FILL_W-1:0]  fill_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               irq_o
);
  logic [FILL_W-1:0]  fill_q;
  logic [ALARM_W-1:0] alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
    end else begin
      unique case ({push_i, pop_i})
        2'b10:   fill_q <= fill_q + FILL_W'(1);
        2'b01:   fill_q <= fill_q - FILL_W'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         alarm_q <= '0;
    else if (alarm_we_i) alarm_q <= alarm_val_i;
  end

  assign fill_o  = fill_q;
  assign full_o  = (fill_q == FILL_W'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign irq_o   = (fill_q > FILL_W'(alarm_q));

  a_r2_fill_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(DEPTH));

  a_r3_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);

  a_r5_alarm_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_we_i |=> (irq_o == (fill_q > FILL_W'($past(alarm_val_i)))));
endmodule

// File: rtl/rx_silo_ovf.sv
module rx_silo_ovf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int ALARM_W = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [CHAR_W-1:0]            wr_char_i,
  input  logic [LINE_W-1:0]            wr_line_i,
  input  logic                         wr_par_err_i,
  input  logic                         wr_frm_err_i,
  input  logic                         wr_ovr_i,
  input  logic                         rd_en_i,
  output logic [ENTRY_W-1:0]           rd_entry_o,
  output logic [$clog2(DEPTH+1)-1:0]   fill_o,
  input  logic                         alarm_we_i,
  input  logic [ALARM_W-1:0]           alarm_val_i,
  output logic                         rx_irq_o,
  output logic                         ovf_o,
  input  logic                         ovf_clr_i
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic                 full, empty, push, pop, drop;
  logic [PAYLOAD_W-1:0] wdata, rdata;
  silo_entry_t          wr_entry, head;

  // a full silo still takes a write when the same cycle frees a slot
  assign pop  = rd_en_i && !empty;
  assign push = wr_en_i && (!full || rd_en_i);
  assign drop = wr_en_i && full && !rd_en_i;

  always_comb begin
    wr_entry         = '0;
    wr_entry.chr     = wr_char_i;
    wr_entry.line    = wr_line_i;
    wr_entry.par_err = wr_par_err_i;
    wr_entry.frm_err = wr_frm_err_i;
    wr_entry.ovr_err = wr_ovr_i;
  end
  assign wdata = wr_entry[PAYLOAD_W-1:0];

  rx_silo_mem #(.DEPTH(DEPTH), .W(PAYLOAD_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  rx_silo_level #(.DEPTH(DEPTH), .ALARM_W(ALARM_W)) u_level (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .alarm_we_i  (alarm_we_i),
    .alarm_val_i (alarm_val_i),
    .fill_o      (fill_o),
    .full_o      (full),
    .empty_o     (empty),
    .irq_o       (rx_irq_o)
  );

  rx_silo_ovf u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (drop),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_o)
  );

  always_comb begin
    head = empty ? '0 : silo_entry_t'({1'b1, rdata});
  end
  assign rd_entry_o = head;

  a_r1_valid_tracks_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_entry_o[ENTRY_W-1] == (fill_o != '0));

  a_r4_empty_read_keeps_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && fill_o == '0) |=> (fill_o == '0));

  a_r6_drop_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && fill_o == FILL_W'(DEPTH)) |=> (fill_o == FILL_W'(DEPTH)) && ovf_o);

  a_r8_full_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && fill_o == FILL_W'(DEPTH) && !ovf_o && !ovf_clr_i)
      |=> (fill_o == FILL_W'(DEPTH)) && !ovf_o);

  a_r3_write_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && fill_o < FILL_W'(DEPTH)) |=> (fill_o == $past(fill_o) + FILL_W'(1)));
endmodule

// File: tb/tb_rx_silo.sv
module tb_rx_silo;
  localparam int DEPTH = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_char_i = '0;
  logic [3:0]  wr_line_i = '0;
  logic        wr_par_err_i = 1'b0, wr_frm_err_i = 1'b0, wr_ovr_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] rd_entry_o;
  logic [6:0]  fill_o;
  logic        alarm_we_i = 1'b0;
  logic [5:0]  alarm_val_i = '0;
  logic        rx_irq_o, ovf_o;
  logic        ovf_clr_i = 1'b0;

  int checks = 0, errors = 0;
  int alarm = 0;
  bit done = 0;
  logic [15:0] mq[$];

  always #2 clk_i = ~clk_i;

  rx_silo dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    wr_en_i = 0; rd_en_i = 0; alarm_we_i = 0; ovf_clr_i = 0;
  endtask

  function automatic logic [14:0] pat(int i);
    logic [7:0] c = 8'((i * 29 + 7) & 8'hff);
    return {3'((i >> 1) & 7), 4'(i & 15), c};
  endfunction

  task automatic drive_wr(logic [14:0] p);
    wr_en_i = 1;
    wr_char_i = p[7:0]; wr_line_i = p[11:8];
    wr_par_err_i = p[12]; wr_frm_err_i = p[13]; wr_ovr_i = p[14];
  endtask

  task automatic set_alarm(int a);
    alarm_we_i = 1; alarm_val_i = 6'(a); alarm = a;
    tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1;
    tick();
    // R9: reset state
    chk("R9 fill", fill_o, 0);
    chk("R9 irq", rx_irq_o, 0);
    chk("R9 ovf", ovf_o, 0);
    chk("R9 entry", rd_entry_o, 0);

    // R4: empty read
    rd_en_i = 1;
    chk("R4 empty word", rd_entry_o, 0);
    tick();
    chk("R4 fill after empty read", fill_o, 0);

    set_alarm(20);
    // R3/R5/R1: fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      drive_wr(pat(i));
      mq.push_back({1'b1, pat(i)});
      tick();
      chk("R3 fill up", fill_o, i + 1);
      chk("R5 irq on fill", rx_irq_o, (i + 1 > alarm));
      chk("R1 head word", rd_entry_o, mq[0]);
      if (i + 1 == 33) begin
        for (int a = 0; a < 64; a++) begin
          set_alarm(a);
          chk("R5 alarm sweep", rx_irq_o, (33 > a));
        end
        set_alarm(20);
      end
    end

    // R6: write to full is dropped
    drive_wr(15'h7abc);
    tick();
    chk("R6 fill stays full", fill_o, DEPTH);
    chk("R6 ovf set", ovf_o, 1);
    chk("R6 head unchanged", rd_entry_o, mq[0]);

    // R7: sticky, set wins, clear
    tick();
    chk("R7 sticky", ovf_o, 1);
    ovf_clr_i = 1; drive_wr(15'h1234);
    tick();
    chk("R7 set beats clear", ovf_o, 1);
    ovf_clr_i = 1;
    tick();
    chk("R7 cleared", ovf_o, 0);

    // R8: simultaneous read and write while full
    rd_en_i = 1; drive_wr(pat(100));
    chk("R8 word before swap", rd_entry_o, mq[0]);
    void'(mq.pop_front());
    mq.push_back({1'b1, pat(100)});
    tick();
    chk("R8 fill", fill_o, DEPTH);
    chk("R8 no ovf", ovf_o, 0);

    // R2: drain in order
    set_alarm(40);
    while (mq.size() > 0) begin
      rd_en_i = 1;
      chk("R2 order", rd_entry_o, mq[0]);
      void'(mq.pop_front());
      tick();
      chk("R3 fill down", fill_o, mq.size());
      chk("R5 irq on drain", rx_irq_o, (mq.size() > alarm));
    end

    rd_en_i = 1;
    chk("R4 empty after drain", rd_entry_o, 0);
    tick();
    chk("R4 fill after drain read", fill_o, 0);

    // R3: read and write together at mid level
    drive_wr(pat(7)); tick();
    drive_wr(pat(8)); tick();
    rd_en_i = 1; drive_wr(pat(9));
    chk("R1 mid head", rd_entry_o, {1'b1, pat(7)});
    tick();
    chk("R3 fill unchanged", fill_o, 2);
    chk("R2 next head", rd_entry_o, {1'b1, pat(8)});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule